// File: doc/BRIEF.md
# Chained Transmit Descriptor Fetch Engine

This block is the fetch side of a transmit DMA. It walks a linked list of transmit descriptors held in system memory. Each descriptor is four 32-bit words at consecutive addresses: status at offset 0, control at 4, buffer address at 8 and next-descriptor address at 12. The engine reads a descriptor over a simple request/acknowledge memory port and checks the ownership flag in its status word. If the DMA owns the descriptor, the engine offers the buffer address, byte length and segment flags on a frame-request interface. When the frame is acknowledged, the engine hands the descriptor back by writing its status word. It then moves on to the next descriptor.

Software loads the address of the first descriptor through a base-address write port and enables the engine with a level input. When the engine meets a descriptor that the CPU owns, it stops and waits in a suspended state. It leaves that state only on a poll-demand pulse, which makes it read the same descriptor's status again. Clearing the enable returns the engine to idle. The next start fetches from the base address again.

Top module: `txdf_engine`

## Requirements
- R1: After reset, and while `txStart` is low, the engine issues no memory request and no frame request, and `suspended` is low.
- R2: When `txStart` is high in idle, the engine reads the status, control, buffer and next words of the descriptor at the list base address, in that order, at byte offsets 0, 4, 8 and 12.
- R3: When status bit 31 reads 1 (DMA owns the descriptor), the engine raises `frmValid` after the fourth word has been read. The frame request carries `frmAddr` from the buffer word, `frmLen` from control bits 10:0, `frmFirst` from control bit 29 and `frmLast` from control bit 30. All of these hold steady until `frmDone`, and no memory request is made while the frame request is up.
- R4: When status bit 31 reads 0 (CPU owns the descriptor), the engine raises `suspended` and skips the other three words. While suspended it issues no memory request and no frame request until a poll demand arrives or it is stopped.
- R5: A `pollDemand` pulse while suspended and enabled makes the engine read the status word of the same descriptor again. The engine then either continues as in R3 or suspends again after that single read.
- R6: On the cycle after `frmDone` is taken, the engine writes the descriptor's status word at the descriptor address. The written value has bit 31 at 0, bits 16:0 at 0, and bits 30:17 equal to the values read from the status word.
- R7: After the status write-back, the next descriptor address is the fourth word when control bit 24 (chained) is 1. When control bit 24 is 0, it is the current descriptor address plus 16.
- R8: A low `txStart` takes effect while suspended (on the next cycle) or after a status write-back. The engine then goes idle and makes no accesses. The next start begins at the most recent value written through `baseWrEn`.
- R9: A memory request keeps its address, direction and write data steady until the cycle in which `memAck` is high. Read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txStart | input | 1 | Transmit enable level |
| baseWrEn | input | 1 | Write strobe for the list base address |
| baseWrData | input | ADDR_W | Byte address of the first descriptor |
| pollDemand | input | 1 | One-cycle pulse asking for the current descriptor to be read again |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write when high |
| memAddr | output | ADDR_W | Byte address of the accessed word |
| memWData | output | 32 | Write data (status write-back) |
| memRData | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Access completes in this cycle |
| frmValid | output | 1 | Frame request pending |
| frmAddr | output | ADDR_W | Buffer address of the frame |
| frmLen | output | LEN_W | Buffer length in bytes |
| frmFirst | output | 1 | Buffer holds the first segment |
| frmLast | output | 1 | Buffer holds the last segment |
| frmDone | input | 1 | Frame request completed |
| suspended | output | 1 | Engine is stopped on a CPU-owned descriptor |

## Verification
Every result in this block is due one rising edge after the acknowledge that triggers it. The next memory address appears at the edge that takes `memAck`. `suspended` rises at the edge that accepts a status word with bit 31 clear. `frmValid` rises at the edge that accepts the fourth word. The write-back request starts at the edge that takes `frmDone`, and a poll or stop leaves the suspended state at the next edge. The bench models the memory and the frame consumer at falling edges with random latencies, and it checks each access and each frame request as it happens against a descriptor walk that it computes itself. Checks on counts, on the suspended state and on the absence of traffic are made only after a settle time longer than the worst-case latency of the sequence under test.

// File: rtl/txdf_pkg.sv
package txdf_pkg;

  // descriptor word and field positions (decoded by software)
  localparam int WORD_W     = 32;
  localparam int OWN_BIT    = 31;
  localparam int LAST_BIT   = 30;
  localparam int FIRST_BIT  = 29;
  localparam int CHAIN_BIT  = 24;
  localparam int KEEP_LO    = 17;                 // status bits kept on write-back start here
  localparam int KEEP_W     = OWN_BIT - KEEP_LO;  // bits 30:17
  localparam int DESC_BYTES = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STS,
    ST_RD_CTL,
    ST_RD_BUF,
    ST_RD_NXT,
    ST_FRAME,
    ST_WR_STS,
    ST_SUSP
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadBase;   // current pointer <- list base
    logic       capSts;     // capture status word
    logic       capCtl;     // capture control word
    logic [1:0] capPtr;     // [0] buffer word, [1] next word
    logic       stepNext;   // advance current pointer
    logic [1:0] wordSel;    // word index within descriptor
  } dpStrobe_t;

endpackage

// File: rtl/txdf_ctrl.sv
module txdf_ctrl
  import txdf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txStart,
  input  logic       pollDemand,
  input  logic       memAck,
  input  logic       frmDone,
  input  logic       rdOwn,
  output dpStrobe_t  strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       frmValid,
  output logic       suspended
);

  engState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: begin
        if (txStart) begin
          strobe.loadBase = 1'b1;
          stateNxt        = ST_RD_STS;
        end
      end
      ST_RD_STS: begin
        strobe.wordSel = 2'd0;
        if (memAck) begin
          strobe.capSts = 1'b1;
          stateNxt      = rdOwn ? ST_RD_CTL : ST_SUSP;
        end
      end
      ST_RD_CTL: begin
        strobe.wordSel = 2'd1;
        if (memAck) begin
          strobe.capCtl = 1'b1;
          stateNxt      = ST_RD_BUF;
        end
      end
      ST_RD_BUF: begin
        strobe.wordSel = 2'd2;
        if (memAck) begin
          strobe.capPtr[0] = 1'b1;
          stateNxt         = ST_RD_NXT;
        end
      end
      ST_RD_NXT: begin
        strobe.wordSel = 2'd3;
        if (memAck) begin
          strobe.capPtr[1] = 1'b1;
          stateNxt         = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (frmDone) stateNxt = ST_WR_STS;
      end
      ST_WR_STS: begin
        strobe.wordSel = 2'd0;
        if (memAck) begin
          strobe.stepNext = 1'b1;
          stateNxt        = txStart ? ST_RD_STS : ST_IDLE;
        end
      end
      ST_SUSP: begin
        if (!txStart)       stateNxt = ST_IDLE;
        else if (pollDemand) stateNxt = ST_RD_STS;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign memReq    = (state == ST_RD_STS) || (state == ST_RD_CTL) ||
                     (state == ST_RD_BUF) || (state == ST_RD_NXT) ||
                     (state == ST_WR_STS);
  assign memWe     = (state == ST_WR_STS);
  assign frmValid  = (state == ST_FRAME);
  assign suspended = (state == ST_SUSP);

endmodule

// File: rtl/txdf_dpath.sv
module txdf_dpath
  import txdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [WORD_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [ADDR_W-1:0] frmAddr,
  output logic [LEN_W-1:0]  frmLen,
  output logic              frmFirst,
  output logic              frmLast,
  output logic              rdOwn
);

  localparam int PTR_N = 2;   // buffer word, next word

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] ptrReg [PTR_N];
  logic [KEEP_W-1:0] keepReg;
  logic [LEN_W-1:0]  lenReg;
  logic              firstReg, lastReg, chainReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         baseReg <= '0;
    else if (baseWrEn) baseReg <= baseWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curAddr <= '0;
    else if (strobe.loadBase) curAddr <= baseReg;
    else if (strobe.stepNext) curAddr <= chainReg ? ptrReg[1]
                                                  : curAddr + ADDR_W'(DESC_BYTES);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              keepReg <= '0;
    else if (strobe.capSts) keepReg <= memRData[OWN_BIT-1:KEEP_LO];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg   <= '0;
      firstReg <= 1'b0;
      lastReg  <= 1'b0;
      chainReg <= 1'b0;
    end else if (strobe.capCtl) begin
      lenReg   <= memRData[LEN_W-1:0];
      firstReg <= memRData[FIRST_BIT];
      lastReg  <= memRData[LAST_BIT];
      chainReg <= memRData[CHAIN_BIT];
    end
  end

  for (genvar g = 0; g < PTR_N; g++) begin : gPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 ptrReg[g] <= '0;
      else if (strobe.capPtr[g]) ptrReg[g] <= memRData[ADDR_W-1:0];
    end
  end

  assign memAddr  = curAddr + ADDR_W'({strobe.wordSel, 2'b00});
  assign memWData = {1'b0, keepReg, {KEEP_LO{1'b0}}};
  assign frmAddr  = ptrReg[0];
  assign frmLen   = lenReg;
  assign frmFirst = firstReg;
  assign frmLast  = lastReg;
  assign rdOwn    = memRData[OWN_BIT];

endmodule

// File: rtl/txdf_engine.sv
module txdf_engine
  import txdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txStart,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic              pollDemand,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  input  logic [WORD_W-1:0] memRData,
  input  logic              memAck,
  output logic              frmValid,
  output logic [ADDR_W-1:0] frmAddr,
  output logic [LEN_W-1:0]  frmLen,
  output logic              frmFirst,
  output logic              frmLast,
  input  logic              frmDone,
  output logic              suspended
);

  dpStrobe_t strobe;
  logic      rdOwn;

  txdf_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .txStart    (txStart),
    .pollDemand (pollDemand),
    .memAck     (memAck),
    .frmDone    (frmDone),
    .rdOwn      (rdOwn),
    .strobe     (strobe),
    .memReq     (memReq),
    .memWe      (memWe),
    .frmValid   (frmValid),
    .suspended  (suspended)
  );

  txdf_dpath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .baseWrEn   (baseWrEn),
    .baseWrData (baseWrData),
    .memRData   (memRData),
    .memAddr    (memAddr),
    .memWData   (memWData),
    .frmAddr    (frmAddr),
    .frmLen     (frmLen),
    .frmFirst   (frmFirst),
    .frmLast    (frmLast),
    .rdOwn      (rdOwn)
  );

endmodule

// File: rtl/txdf_engine_chk.sv
module txdf_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              txStart,
  input logic              pollDemand,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck,
  input logic              frmValid,
  input logic [ADDR_W-1:0] frmAddr,
  input logic [LEN_W-1:0]  frmLen,
  input logic              frmDone,
  input logic              suspended
);

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R9

  AST_FRM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && !frmDone |=> frmValid && $stable(frmAddr) && $stable(frmLen)); // R3

  AST_FRM_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    frmValid |-> !memReq); // R3

  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !memReq && !frmValid); // R4

  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    suspended && txStart && !pollDemand |=> suspended); // R4

  AST_POLL_REREAD: assert property (@(posedge clk) disable iff (!rstN)
    suspended && txStart && pollDemand |=> memReq && !memWe); // R5

  AST_WB_AFTER_FRM: assert property (@(posedge clk) disable iff (!rstN)
    frmValid && frmDone |=> memReq && memWe); // R6

  AST_STOP_SUSP: assert property (@(posedge clk) disable iff (!rstN)
    suspended && !txStart |=> !suspended && !memReq); // R8

endmodule

bind txdf_engine txdf_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .txStart    (txStart),
  .pollDemand (pollDemand),
  .memReq     (memReq),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .memAck     (memAck),
  .frmValid   (frmValid),
  .frmAddr    (frmAddr),
  .frmLen     (frmLen),
  .frmDone    (frmDone),
  .suspended  (suspended)
);

// File: tb/txdf_engine_test.sv
module txdf_engine_test;
  localparam int AW = 32;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          txStart = 1'b0;
  logic          baseWrEn = 1'b0;
  logic [AW-1:0] baseWrData = '0;
  logic          pollDemand = 1'b0;
  logic          memAck = 1'b0;
  logic [31:0]   memRData = '0;
  logic          frmDone = 1'b0;
  logic          memReq, memWe, frmValid, frmFirst, frmLast, suspended;
  logic [AW-1:0] memAddr, frmAddr;
  logic [31:0]   memWData;
  logic [LW-1:0] frmLen;

  txdf_engine #(.ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rstN(rstN), .txStart(txStart), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .pollDemand(pollDemand), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData), .memRData(memRData),
    .memAck(memAck), .frmValid(frmValid), .frmAddr(frmAddr), .frmLen(frmLen),
    .frmFirst(frmFirst), .frmLast(frmLast), .frmDone(frmDone), .suspended(suspended)
  );

  initial forever #5 clk = ~clk;

  logic [31:0]   mem [0:63];
  int            tests = 0;
  int            fails = 0;
  logic [AW-1:0] expPtr = '0;
  int            rdPhase = 0;
  int            nReads = 0;
  int            nWrites = 0;
  int            nFrames = 0;
  bit            finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] wbValue(input logic [31:0] sts);
    return {1'b0, sts[30:17], 17'b0};
  endfunction

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] cur);
    int i;
    i = int'(cur[7:2]);
    return mem[i+1][24] ? mem[i+3][AW-1:0] : cur + AW'(16);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int slot, input bit own, input bit chain,
                          input logic [31:0] nxt);
    logic [10:0] len;
    logic [30:0] sts;
    bit          first, last;
    len   = 11'($urandom);
    sts   = 31'($urandom);
    first = 1'($urandom);
    last  = 1'($urandom);
    mem[slot*4]   = {own, sts};
    mem[slot*4+1] = {1'b0, last, first, 4'b0, chain, 13'b0, len};
    mem[slot*4+2] = $urandom;
    mem[slot*4+3] = nxt;
  endtask

  task automatic build_chain(input int n, input int start, input int step);
    for (int k = 0; k <= n; k++) begin
      int s, s2;
      s  = (start + k * step) % 16;
      s2 = (start + (k + 1) * step) % 16;
      put_desc(s, k < n, 1'b1, 32'(s2 * 16));
    end
  endtask

  task automatic write_base(input logic [AW-1:0] v);
    baseWrData = v;
    baseWrEn   = 1'b1;
    tick(1);
    baseWrEn   = 1'b0;
  endtask

  task automatic pulse_poll();
    pollDemand = 1'b1;
    tick(1);
    pollDemand = 1'b0;
  endtask

  // memory model: random latency, checks every access against the bench walk
  initial begin : memSlave
    bit busy;
    int lat;
    int idx;
    busy = 1'b0;
    lat  = 0;
    forever begin
      @(negedge clk);
      if (memAck) memAck = 1'b0;
      else if (memReq) begin
        if (!busy) begin
          busy = 1'b1;
          lat  = int'($urandom % 3);
        end
        if (lat == 0) begin
          busy = 1'b0;
          idx  = int'(memAddr[7:2]);
          if (memWe) begin
            check(memAddr == expPtr, "R6 write-back address", memAddr, expPtr);
            check(memWData == wbValue(mem[idx]), "R6 write-back data",
                  memWData, wbValue(mem[idx]));
            expPtr = nextPtr(expPtr);   // R7 expected next descriptor
            mem[idx] = memWData;
            nWrites++;
            rdPhase = 0;
          end else begin
            check(memAddr == expPtr + AW'(4 * rdPhase), "R2 R7 read address",
                  memAddr, expPtr + AW'(4 * rdPhase));
            memRData = mem[idx];
            nReads++;
            if (!(rdPhase == 0 && !mem[idx][31])) rdPhase++;
          end
          memAck = 1'b1;
        end else lat--;
      end
    end
  end

  // frame consumer: random completion latency, checks the request contents
  initial begin : frmSlave
    bit inFrm;
    int lat;
    int idx;
    inFrm = 1'b0;
    lat   = 0;
    forever begin
      @(negedge clk);
      if (frmDone) frmDone = 1'b0;
      else if (frmValid) begin
        if (!inFrm) begin
          inFrm = 1'b1;
          lat   = int'($urandom % 4);
          idx   = int'(expPtr[7:2]);
          check(mem[idx][31], "R3 frame only for DMA-owned descriptor",
                mem[idx], 32'h8000_0000);
          check(frmAddr == mem[idx+2][AW-1:0], "R3 frame buffer address",
                frmAddr, mem[idx+2]);
          check(frmLen == mem[idx+1][10:0], "R3 frame length",
                32'(frmLen), 32'(mem[idx+1][10:0]));
          check({frmLast, frmFirst} == mem[idx+1][30:29], "R3 first/last flags",
                32'({frmLast, frmFirst}), 32'(mem[idx+1][30:29]));
          nFrames++;
        end
        if (lat == 0) begin
          frmDone = 1'b1;
          inFrm   = 1'b0;
        end else lat--;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : mainSeq
    int r0, w0, f0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) mem[i] = '0;

    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    check(!memReq, "R1 no memory request after reset", 32'(memReq), 0);
    check(!frmValid, "R1 no frame request after reset", 32'(frmValid), 0);
    check(!suspended, "R1 not suspended after reset", 32'(suspended), 0);
    write_base(AW'(48));
    tick(10);
    check(nReads == 0 && !memReq, "R1 idle while txStart low", 32'(nReads), 0);

    // directed: chain of six, then a CPU-owned entry
    build_chain(6, 3, 7);
    expPtr = AW'(48);
    rdPhase = 0;
    txStart = 1'b1;
    tick(300);
    check(nFrames == 6, "R3 frames from owned chain", 32'(nFrames), 6);
    check(nWrites == 6, "R6 write-backs for owned chain", 32'(nWrites), 6);
    check(suspended, "R4 suspended on CPU-owned descriptor", 32'(suspended), 1);
    r0 = nReads;
    tick(25);
    check(nReads == r0 && suspended, "R4 no traffic while suspended",
          32'(nReads - r0), 0);

    // R5: hand the suspended descriptor to the DMA, then poll
    put_desc((3 + 6 * 7) % 16, 1'b1, 1'b1, 32'(((3 + 7 * 7) % 16) * 16));
    mem[((3 + 7 * 7) % 16) * 4][31] = 1'b0;
    f0 = nFrames;
    pulse_poll();
    tick(60);
    check(nFrames == f0 + 1, "R5 poll resumes at same descriptor",
          32'(nFrames - f0), 1);
    check(suspended, "R5 suspends again on next CPU-owned", 32'(suspended), 1);

    // R5: poll with descriptor still CPU-owned
    r0 = nReads;
    f0 = nFrames;
    pulse_poll();
    tick(30);
    check(nReads == r0 + 1, "R5 single status re-read", 32'(nReads - r0), 1);
    check(nFrames == f0 && suspended, "R5 still suspended after re-read",
          32'(nFrames - f0), 0);

    // R8: stop while suspended
    txStart = 1'b0;
    tick(2);
    check(!suspended, "R8 stop leaves suspended state", 32'(suspended), 0);
    r0 = nReads;
    tick(20);
    check(nReads == r0 && !memReq, "R8 idle after stop", 32'(nReads - r0), 0);

    // R7: contiguous step for non-chained entry; R8: latest base used
    put_desc(8, 1'b1, 1'b0, 32'h0000_00f0);
    put_desc(9, 1'b1, 1'b1, 32'd32);
    put_desc(2, 1'b1, 1'b1, 32'd192);
    put_desc(12, 1'b0, 1'b1, 32'd0);
    write_base(AW'(16));
    write_base(AW'(128));
    expPtr = AW'(128);
    rdPhase = 0;
    f0 = nFrames;
    txStart = 1'b1;
    tick(150);
    check(nFrames == f0 + 3, "R7 non-chained then chained walk",
          32'(nFrames - f0), 3);
    check(suspended, "R7 walk ends on CPU-owned entry", 32'(suspended), 1);

    // constrained random rounds: stop, rebuild, restart from new base
    for (int rnd = 0; rnd < 4; rnd++) begin
      int n, st, sp;
      txStart = 1'b0;
      tick(3);
      n  = 1 + int'($urandom % 5);
      st = int'($urandom % 16);
      sp = 2 * int'($urandom % 8) + 1;
      build_chain(n, st, sp);
      write_base(AW'(st * 16));
      expPtr = AW'(st * 16);
      rdPhase = 0;
      f0 = nFrames;
      txStart = 1'b1;
      tick(220);
      check(nFrames == f0 + n, "R8 random restart frame count",
            32'(nFrames - f0), 32'(n));
      check(suspended, "R4 random chain ends suspended", 32'(suspended), 1);
    end

    // R8: stop during a frame; frame and write-back finish, then idle
    txStart = 1'b0;
    tick(3);
    build_chain(3, 5, 3);
    write_base(AW'(80));
    expPtr = AW'(80);
    rdPhase = 0;
    r0 = nReads;
    w0 = nWrites;
    f0 = nFrames;
    txStart = 1'b1;
    for (int i = 0; i < 100 && !frmValid; i++) tick(1);
    txStart = 1'b0;
    tick(40);
    check(nFrames == f0 + 1 && nWrites == w0 + 1, "R8 frame completes after stop",
          32'(nWrites - w0), 1);
    check(nReads == r0 + 4 && !suspended && !memReq, "R8 no fetch after stop",
          32'(nReads - r0), 4);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule